// File: doc/BRIEF.md
# Two-Wire Bus Address Front End with High-Speed Entry

This block sits behind the SCL and SDA pads of a two-wire serial slave. It oversamples both lines with a fast system clock and detects START, repeated START and STOP conditions. It shifts in the first byte after every START. When the upper seven bits equal the fixed device address, the block acknowledges by enabling the open-drain SDA pull-down for the ninth clock. It also reports the transfer direction and pulses an address-hit strobe.

A first byte of the form 00001xxx is a general high-speed master code. Every slave on the bus takes it. The block answers it with a not-acknowledge and raises a high-speed flag. The master then sends a repeated START and a fresh address, and that address is matched and acknowledged in the normal way. The flag stays up until a STOP. A bus-busy output shows whether a START has been seen without a later STOP. Data bytes after the address are handled elsewhere.

Top module: `tws_addr_front`

## Requirements
- R1: After reset, sda_oe, addr_hit, hs_mode and bus_busy are all 0 and the SDA line is released.
- R2: START (SDA falling while SCL is high) sets bus_busy. STOP (SDA rising while SCL is high) clears it.
- R3: When the first byte after a START or repeated START has upper seven bits 0110110 (MSB first), the block pulses addr_hit exactly once. It holds SDA low from the first to the last sample of the ninth SCL high phase, and releases SDA after the ninth SCL falling edge.
- R4: At an address hit, rd_nwr takes bit 0 of the byte (the eighth bit received): 1 means the master reads and 0 means the master writes.
- R5: A first byte that is neither a matching address nor a master code gets no acknowledge and no strobe. All further bits are ignored until the next START or repeated START.
- R6: A first byte whose upper five bits are 00001 gets a not-acknowledge: SDA stays high during the ninth clock. hs_mode is 1 after the ninth SCL falling edge.
- R7: While hs_mode is 1, a repeated START followed by the matching address is acknowledged and strobed as in R3, and hs_mode stays 1.
- R8: A STOP at any point, including in the middle of a byte, clears hs_mode.
- R9: SCL and SDA activity with no START before it gives no acknowledge and no strobe.
- R10: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input (wired line level) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_hit | output | 1 | One-cycle strobe on an address match |
| rd_nwr | output | 1 | Direction of the last matched address, 1 = read |
| hs_mode | output | 1 | High-speed mode flag |
| bus_busy | output | 1 | START seen with no STOP since |

## Verification
The bench uses the default parameters: two synchroniser stages, address 0110110 and master-code prefix 00001. It sweeps all 256 values of the first byte after a START. This covers both directions of the matching address, all eight master-code variants and every non-matching byte, and each transfer ends with a STOP that must clear the flag. Separate sequences cover repeated START inside high-speed mode, a STOP in the middle of a byte, bits clocked after a rejected address, and clocking with no START.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACK  = 2'd2,
        ST_NACK = 2'd3
    } tws_state_e;
endpackage

// File: rtl/tws_line_sync.sv
// Synchronises SCL/SDA and derives edge and bus-condition pulses.
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.scl[0] = scl_i;
        r_d.sda[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.scl[i] = r_q.scl[i-1];
            r_d.sda[i] = r_q.sda[i-1];
        end
        r_d.scl_p = r_q.scl[STAGES-1];
        r_d.sda_p = r_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign scl_s     = r_q.scl[STAGES-1];
    assign sda_s     = r_q.sda[STAGES-1];
    assign scl_rise  = scl_s & ~r_q.scl_p;
    assign scl_fall  = ~scl_s & r_q.scl_p;
    assign start_det = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
endmodule

// File: rtl/tws_byte_shift.sv
// Collects the first byte MSB first on SCL rising edges.
module tws_byte_shift #(
    parameter int BW = 8,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          scl_rise,
    input  logic          sda_s,
    output logic [BW-1:0] byte_q,
    output logic [CW-1:0] cnt_q
);
    typedef struct packed {
        logic [BW-1:0] sh;
        logic [CW-1:0] cnt;
    } shf_t;

    shf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else if (en && scl_rise && (r_q.cnt != CW'(BW))) begin
            r_d.sh  = {r_q.sh[BW-2:0], sda_s};
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign byte_q = r_q.sh;
    assign cnt_q  = r_q.cnt;
endmodule

// File: rtl/tws_addr_fsm.sv
// Decides on the first byte: acknowledge, master code or ignore.
module tws_addr_fsm
    import tws_pkg::*;
#(
    parameter int              ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] SLV_ADDR = 7'b0110110,
    parameter int              PFX_W    = 5,
    parameter logic [PFX_W-1:0] HS_PFX  = 5'b00001,
    localparam int BW = ADDR_W + 1,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          scl_fall,
    input  logic [BW-1:0] byte_i,
    input  logic [CW-1:0] cnt_i,
    output logic          shift_en,
    output logic          sda_oe,
    output logic          addr_hit,
    output logic          rd_nwr,
    output logic          hs_mode,
    output logic          bus_busy
);
    typedef struct packed {
        tws_state_e st;
        logic       oe;
        logic       hit;
        logic       rnw;
        logic       hs;
        logic       busy;
    } fsm_t;

    fsm_t r_d, r_q;
    logic byte_done, is_me, is_code;

    assign byte_done = scl_fall && (cnt_i == CW'(BW));
    assign is_me     = (byte_i[BW-1:1] == SLV_ADDR);
    assign is_code   = (byte_i[BW-1 -: PFX_W] == HS_PFX);

    always_comb begin
        r_d     = r_q;
        r_d.hit = 1'b0;
        if (stop_det) begin
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b0;
            r_d.hs   = 1'b0;
            r_d.busy = 1'b0;
        end else if (start_det) begin
            r_d.st   = ST_ADDR;
            r_d.oe   = 1'b0;
            r_d.busy = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (byte_done) begin
                        if (is_me) begin
                            r_d.st  = ST_ACK;
                            r_d.oe  = 1'b1;
                            r_d.hit = 1'b1;
                            r_d.rnw = byte_i[0];
                        end else if (is_code) begin
                            r_d.st = ST_NACK;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_IDLE;
                    end
                end
                ST_NACK: begin
                    if (scl_fall) begin
                        r_d.hs = 1'b1;
                        r_d.st = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign shift_en = (r_q.st == ST_ADDR);
    assign sda_oe   = r_q.oe;
    assign addr_hit = r_q.hit;
    assign rd_nwr   = r_q.rnw;
    assign hs_mode  = r_q.hs;
    assign bus_busy = r_q.busy;
endmodule

// File: rtl/tws_addr_front.sv
module tws_addr_front #(
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] SLV_ADDR    = 7'b0110110,
    parameter int                PFX_W       = 5,
    parameter logic [PFX_W-1:0]  HS_PFX      = 5'b00001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic addr_hit,
    output logic rd_nwr,
    output logic hs_mode,
    output logic bus_busy
);
    localparam int BW = ADDR_W + 1;
    localparam int CW = $clog2(BW + 1);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          shift_en;
    logic [BW-1:0] byte_w;
    logic [CW-1:0] cnt_w;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    tws_byte_shift #(.BW(BW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_det | stop_det),
        .en      (shift_en),
        .scl_rise(scl_rise),
        .sda_s   (sda_s),
        .byte_q  (byte_w),
        .cnt_q   (cnt_w)
    );

    tws_addr_fsm #(
        .ADDR_W  (ADDR_W),
        .SLV_ADDR(SLV_ADDR),
        .PFX_W   (PFX_W),
        .HS_PFX  (HS_PFX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_fall (scl_fall),
        .byte_i   (byte_w),
        .cnt_i    (cnt_w),
        .shift_en (shift_en),
        .sda_oe   (sda_oe),
        .addr_hit (addr_hit),
        .rd_nwr   (rd_nwr),
        .hs_mode  (hs_mode),
        .bus_busy (bus_busy)
    );
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic addr_hit,
    input logic hs_mode,
    input logic bus_busy
);
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_hit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> !addr_hit);

    assert_hit_drives_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> sda_oe);

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> bus_busy);

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!hs_mode && !bus_busy));

    assert_hs_rise_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> !sda_oe);
endmodule

bind tws_addr_front tws_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .addr_hit (addr_hit),
    .hs_mode  (hs_mode),
    .bus_busy (bus_busy)
);

// File: tb/sim_tws_addr_front.sv
`timescale 1ns/1ps
module sim_tws_addr_front;
    localparam int Q = 6;
    localparam logic [6:0] MY_ADDR = 7'b0110110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, addr_hit, rd_nwr, hs_mode, bus_busy;

    int vectors = 0;
    int errors  = 0;
    int hit_cnt = 0;
    logic last_rd = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tws_addr_front u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_hit(addr_hit), .rd_nwr(rd_nwr),
        .hs_mode(hs_mode), .bus_busy(bus_busy)
    );

    always @(posedge clk) begin
        if (addr_hit) begin
            hit_cnt <= hit_cnt + 1;
            last_rd <= rd_nwr;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic start_cond();
        sda_m = 1'b1; scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;
    endtask

    task automatic rstart_cond();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s1, output logic s2);
        tick(Q); sda_m = b;
        tick(Q); scl = 1'b1;
        tick(Q); s1 = sda_line;
        tick(Q); s2 = sda_line;
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic a, b;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], a, b);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        logic s1, s2;
        int h0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk("R1 oe", sda_oe, 0);
        chk("R1 hit", addr_hit, 0);
        chk("R1 hs", hs_mode, 0);
        chk("R1 busy", bus_busy, 0);
        chk("R1 line", sda_line, 1);

        // Sweep every first byte after START
        for (int v = 0; v < 256; v++) begin
            logic [7:0] bv;
            logic ea, eh;
            bv = 8'(v);
            ea = (bv[7:1] == MY_ADDR);
            eh = (bv[7:3] == 5'b00001);
            h0 = hit_cnt;
            start_cond();
            tick(2);
            chk("R2 busy after start", bus_busy, 1);
            send_byte(bv);
            clk_bit(1'b1, s1, s2);
            chk(ea ? "R3 ack first" : (eh ? "R6 nack first" : "R5 nack first"), s1, !ea);
            chk(ea ? "R3 ack last" : (eh ? "R6 nack last" : "R5 nack last"), s2, !ea);
            tick(Q);
            chk("R3 release after ninth", sda_line, 1);
            chk(ea ? "R3 one strobe" : "R5 no strobe", hit_cnt - h0, ea);
            if (ea) chk("R4 direction", last_rd, bv[0]);
            chk("R6 hs flag", hs_mode, eh);
            stop_cond();
            chk("R8 hs cleared by stop", hs_mode, 0);
            chk("R2 busy after stop", bus_busy, 0);
        end

        // R7: master code, repeated START, address in high-speed mode
        for (int rw = 0; rw < 2; rw++) begin
            h0 = hit_cnt;
            start_cond();
            send_byte(8'h0D);
            clk_bit(1'b1, s1, s2);
            chk("R6 code nack", s2, 1);
            tick(Q);
            chk("R6 hs set", hs_mode, 1);
            rstart_cond();
            tick(2);
            chk("R7 hs kept over Sr", hs_mode, 1);
            chk("R7 busy over Sr", bus_busy, 1);
            send_byte({MY_ADDR, 1'(rw)});
            clk_bit(1'b1, s1, s2);
            chk("R7 ack first", s1, 0);
            chk("R7 ack last", s2, 0);
            tick(Q);
            chk("R7 strobe", hit_cnt - h0, 1);
            chk("R7 direction", last_rd, rw);
            chk("R7 hs still set", hs_mode, 1);
            // wrong address in HS mode after another Sr
            rstart_cond();
            send_byte(8'hA4);
            clk_bit(1'b1, s1, s2);
            chk("R5 hs wrong addr nack", s2, 1);
            tick(Q);
            chk("R7 hs survives mismatch", hs_mode, 1);
            stop_cond();
            chk("R8 stop clears hs", hs_mode, 0);
        end

        // R8: STOP in the middle of a byte
        start_cond();
        send_byte(8'h08);
        clk_bit(1'b1, s1, s2);
        tick(Q);
        chk("R6 hs set again", hs_mode, 1);
        rstart_cond();
        clk_bit(1'b0, s1, s2);
        clk_bit(1'b1, s1, s2);
        clk_bit(1'b1, s1, s2);
        tick(Q);
        stop_cond();
        chk("R8 mid-byte stop hs", hs_mode, 0);
        chk("R8 mid-byte stop busy", bus_busy, 0);

        // R5: bits after a rejected address are ignored
        h0 = hit_cnt;
        start_cond();
        send_byte(8'h55);
        clk_bit(1'b1, s1, s2);
        chk("R5 reject nack", s2, 1);
        send_byte({MY_ADDR, 1'b0});
        clk_bit(1'b1, s1, s2);
        chk("R5 later bits ignored", s2, 1);
        tick(Q);
        chk("R5 no strobe after reject", hit_cnt - h0, 0);
        stop_cond();

        // R9: clocking with no START
        h0 = hit_cnt;
        tick(Q);
        scl = 1'b0;
        send_byte({MY_ADDR, 1'b1});
        clk_bit(1'b1, s1, s2);
        chk("R9 no ack without start", s2, 1);
        chk("R9 no ack first", s1, 1);
        tick(Q);
        chk("R9 no strobe", hit_cnt - h0, 0);
        chk("R9 not busy", bus_busy, 0);
        scl = 1'b1;
        tick(Q);

        // R10: oe only moves while SCL low is checked by a bound property;
        // here the line must idle high once traffic ends.
        chk("R10 line idle", sda_line, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule